// File: doc/BRIEF.md
# Synchronous Burst Static RAM with Dual Address Strobes

This block is a synthesizable behavioural model of a pipelined static RAM that answers a processor and a memory controller over one shared synchronous bus. Each word holds four byte lanes of nine bits: eight data bits and one parity bit. A transfer starts when either of two active-low address strobes loads an address, provided the three chip enables select the device. A two-bit burst counter then steps through the four words of an aligned group while the advance input is held low.

Writes go either to all four lanes through a global write enable, or to chosen lanes through a byte write enable and four per-lane selects. Read data always shows the word at the address registered at the last clock edge, and an asynchronous output enable gates it. A sleep input freezes the block while keeping its contents. The data ports are separate input, output and output-enable signals, not a tristate pad. The memory has fixed timing and no stall, so there is no valid/ready handshake and no back-pressure: a driver that cannot accept data must hold the output enable high.

Top module: `sync_burst_sram`

## Requirements
- R1: At a rising edge where a load is taken and the enables select the device (enable 1 low, enable 2 high, enable 3 low), the full address is registered. Its two lowest bits seed the burst counter, and the device becomes active.
- R2: When both strobes are low with enable 1 low, the processor strobe wins. A processor-strobe load never writes. A controller-strobe load that selects the device writes at the address just presented, in the same edge.
- R3: The processor strobe is ignored while enable 1 is high. The controller strobe then decides, and with no strobe the cycle is a burst continuation.
- R4: Enables 2 and 3 are looked at only in a load cycle. In continuation cycles their values have no effect.
- R5: In a continuation cycle of an active device, advance low increments the counter modulo 4 (3 wraps to 0) and leaves the upper address bits alone. Advance high holds the counter.
- R6: In a write slot, global write low writes all four lanes whatever the byte write enable and selects say.
- R7: With global write high, lane i (bits 9i+8 down to 9i, parity in the top bit) is written only if byte write enable is low and select i is low.
- R8: A continuation write of an active device goes to the address registered before the edge. The counter then advances.
- R9: The read data output shows the word at the registered address right after the edge that registered it. The output enable acts without a clock: output-enable high forces the data-valid flag and the data output to zero.
- R10: In the first cycle after a load takes the device from deselected to selected, the data-valid flag stays low whatever the output enable does.
- R11: While sleep is high, every synchronous input is ignored, the state and contents are kept, and the data-valid flag is low. Operation resumes from the same state once sleep returns low.
- R12: A load with enables that do not select the device deselects it. A deselected device does not write, and its data-valid flag is low.
- R13: Reset clears the memory and leaves the device deselected, with the data-valid flag and the data output at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | AW | External address |
| en1_n | input | 1 | Chip enable 1, active low |
| en2 | input | 1 | Chip enable 2, active high |
| en3_n | input | 1 | Chip enable 3, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwr_n | input | 1 | Byte write enable, active low |
| lane_sel_n | input | 4 | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, active high |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| rdata_o | output | 36 | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data is driven (output enable) |

## Verification
The bench runs a burst past index 3 and expects the read to fall back to the group's first word. A counter that carries into the upper address would read a different group. Both strobes are asserted together with a write request: a design that let the controller strobe win would overwrite that word. Enables 2 and 3 are toggled during continuation, and the processor strobe is asserted with enable 1 high. A design that decodes the enables on every cycle would deselect at those points, and one that still honours the strobe would jump to a new address. Writes are issued while deselected and while sleeping, and the output enable is checked right after a load from deselect, to catch stray writes and an unmasked first output.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 9;
  localparam int WORD_W  = LANES * LANE_W;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    LD_NONE = 2'd0,
    LD_PROC = 2'd1,
    LD_CTRL = 2'd2
  } ld_kind_e;
endpackage

// File: rtl/sbs_addr_unit.sv
module sbs_addr_unit
  import sbs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sleep_i,
  input  logic [AW-1:0] addr_i,
  input  logic          en1_n,
  input  logic          en2,
  input  logic          en3_n,
  input  logic          pstb_n,
  input  logic          cstb_n,
  input  logic          adv_n,
  output ld_kind_e      kind_o,
  output logic          sel_o,
  output logic [AW-1:0] cur_addr_o,
  output logic          active_o,
  output logic          first_o
);
  localparam int HI_W = AW - BURST_W;

  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] cnt_q;
  logic               active_q;
  logic               first_q;
  logic               proc_hit;
  logic               ctrl_hit;

  // processor strobe counts only with enable 1 low; it outranks the controller
  assign proc_hit = !pstb_n && !en1_n;
  assign ctrl_hit = !cstb_n && !proc_hit;
  assign kind_o   = proc_hit ? LD_PROC : (ctrl_hit ? LD_CTRL : LD_NONE);
  assign sel_o    = !en1_n && en2 && !en3_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q     <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
    end else if (!sleep_i) begin
      if (kind_o != LD_NONE) begin
        active_q <= sel_o;
        first_q  <= sel_o && !active_q;
        if (sel_o) begin
          hi_q  <= addr_i[AW-1:BURST_W];
          cnt_q <= addr_i[BURST_W-1:0];
        end
      end else begin
        first_q <= 1'b0;
        if (active_q && !adv_n) cnt_q <= cnt_q + BURST_W'(1);
      end
    end
  end

  assign cur_addr_o = {hi_q, cnt_q};
  assign active_o   = active_q;
  assign first_o    = first_q;

  assert_load_seed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && kind_o != LD_NONE && !en1_n && en2 && !en3_n)
      |=> (active_q && cur_addr_o == $past(addr_i)));

  assert_proc_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && en1_n && cstb_n) |=> ($stable(hi_q) && $stable(active_q)));

  assert_burst_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && pstb_n && cstb_n && active_q && !adv_n)
      |=> (cnt_q == $past(cnt_q) + BURST_W'(1) && $stable(hi_q)));

  assert_burst_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_i && (pstb_n || en1_n) && cstb_n && adv_n) |=> $stable(cnt_q));

  assert_sleep_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> ($stable(cnt_q) && $stable(hi_q) && $stable(active_q) && $stable(first_q)));
endmodule

// File: rtl/sbs_lane_decode.sv
module sbs_lane_decode
  import sbs_pkg::*;
(
  input  logic             slot_i,
  input  logic             gwr_n,
  input  logic             bwr_n,
  input  logic [LANES-1:0] lane_sel_n,
  output logic [LANES-1:0] we_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign we_o[g] = slot_i && (!gwr_n || (!bwr_n && !lane_sel_n[g]));
  end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
  import sbs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
      end else if (we_i[g]) begin
        mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end

    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr_i,
  input  logic              en1_n,
  input  logic              en2,
  input  logic              en3_n,
  input  logic              pstb_n,
  input  logic              cstb_n,
  input  logic              adv_n,
  input  logic              gwr_n,
  input  logic              bwr_n,
  input  logic [LANES-1:0]  lane_sel_n,
  input  logic              oe_n,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              rvalid_o
);
  ld_kind_e          kind;
  logic              sel;
  logic [AW-1:0]     cur_addr;
  logic              active;
  logic              first;
  logic              wr_slot;
  logic [AW-1:0]     waddr;
  logic [LANES-1:0]  we;
  logic [WORD_W-1:0] mem_rd;

  sbs_addr_unit #(.AW(AW)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .addr_i     (addr_i),
    .en1_n      (en1_n),
    .en2        (en2),
    .en3_n      (en3_n),
    .pstb_n     (pstb_n),
    .cstb_n     (cstb_n),
    .adv_n      (adv_n),
    .kind_o     (kind),
    .sel_o      (sel),
    .cur_addr_o (cur_addr),
    .active_o   (active),
    .first_o    (first)
  );

  // controller-strobe loads write at once; continuation writes use the held address
  assign wr_slot = !sleep_i && (((kind == LD_CTRL) && sel) || ((kind == LD_NONE) && active));
  assign waddr   = (kind == LD_CTRL) ? addr_i : cur_addr;

  sbs_lane_decode u_dec (
    .slot_i     (wr_slot),
    .gwr_n      (gwr_n),
    .bwr_n      (bwr_n),
    .lane_sel_n (lane_sel_n),
    .we_o       (we)
  );

  sbs_array #(.AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (cur_addr),
    .rdata_o (mem_rd)
  );

  assign rvalid_o = !oe_n && !sleep_i && active && !first;
  assign rdata_o  = rvalid_o ? mem_rd : '0;

  assert_proc_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == LD_PROC) |-> (we == '0));

  assert_global_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_slot && !gwr_n) |-> (&we));

  assert_bwe_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gwr_n && bwr_n) |-> (we == '0));

  assert_first_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    first |-> !rvalid_o);

  assert_desel_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && kind == LD_NONE) |-> (we == '0 && !rvalid_o));

  assert_sleep_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> (we == '0 && !rvalid_o));
endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 4;
  localparam int N  = 18;

  localparam logic [35:0] WA = 36'h8_8888_8888;
  localparam logic [35:0] WB = 36'h1_2345_6789;
  localparam logic [35:0] WC = 36'h9_ABCD_EF01;
  localparam logic [35:0] WD = 36'hF_FFFF_FFFF;
  localparam logic [35:0] WE = 36'h5_A5A5_A5A5;
  localparam logic [35:0] WF = 36'h7_7777_7777;
  localparam logic [35:0] WG = 36'h0_0000_0000;
  localparam logic [35:0] WH = 36'h3_C3C3_C3C3;
  localparam logic [35:0] WM = 36'hF_F803_FE00; // WD with lanes 0 and 2 taken from WG

  // {pstb_n,cstb_n,adv_n}_{en1_n,en2,en3_n}_{gwr_n,bwr_n}_{lane_sel_n}, addr, wdata, rvalid, rdata
  localparam logic [88:0] TBL [N] = '{
    {12'b101_010_01_1111, 4'd4, WA, 1'b0, 36'h0}, //  0 R1 R2 R10: ctrl load+write, first masked
    {12'b110_101_01_1111, 4'd0, WB, 1'b1, 36'h0}, //  1 R8: write at 4, advance to 5
    {12'b110_101_01_1111, 4'd0, WC, 1'b1, 36'h0}, //  2 R8: write at 5
    {12'b110_101_01_1111, 4'd0, WD, 1'b1, 36'h0}, //  3 R8: write at 6
    {12'b110_101_01_1111, 4'd0, WE, 1'b1, WB},    //  4 R5: write at 7, wrap to 4
    {12'b110_101_11_1111, 4'd0, WG, 1'b1, WC},    //  5 R5: read 5
    {12'b001_010_01_1111, 4'd6, WF, 1'b1, WD},    //  6 R2: both strobes, no write
    {12'b111_101_10_1010, 4'd0, WG, 1'b1, WM},    //  7 R7 R4: lanes 0,2, enables don't care
    {12'b110_101_11_0000, 4'd0, WH, 1'b1, WE},    //  8 R7: byte enable high, no write
    {12'b011_101_01_1111, 4'd0, WH, 1'b1, WH},    //  9 R3: proc strobe ignored, continuation write
    {12'b101_110_01_1111, 4'd7, WF, 1'b0, 36'h0}, // 10 R3 R12: ctrl strobe with en1 high deselects
    {12'b110_101_01_1111, 4'd0, WF, 1'b0, 36'h0}, // 11 R12: no write while deselected
    {12'b011_010_11_1111, 4'd7, WG, 1'b0, 36'h0}, // 12 R10: proc load from deselect masked
    {12'b111_101_11_1111, 4'd0, WG, 1'b1, WH},    // 13 R12: word 7 untouched
    {12'b101_010_11_1111, 4'd4, WG, 1'b1, WB},    // 14 R1: load while active, no mask
    {12'b101_000_01_1111, 4'd0, WF, 1'b0, 36'h0}, // 15 R12: en2 low deselects, write dropped
    {12'b101_010_11_1111, 4'd0, WG, 1'b0, 36'h0}, // 16 R10: first cycle masked
    {12'b111_101_11_1111, 4'd0, WG, 1'b1, 36'h0}  // 17 R12 R13: word 0 still cleared
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          en1_n, en2, en3_n, pstb_n, cstb_n, adv_n, gwr_n, bwr_n, oe_n, sleep_i;
  logic [3:0]    lane_sel_n;
  logic [35:0]   wdata_i;
  logic [35:0]   rdata_o;
  logic          rvalid_o;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sync_burst_sram #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n), .gwr_n(gwr_n), .bwr_n(bwr_n),
    .lane_sel_n(lane_sel_n), .oe_n(oe_n), .sleep_i(sleep_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic string row_tag(int i);
    case (i)
      0: return "R1/R2/R10";
      1, 2, 3: return "R8";
      4, 5: return "R5";
      6: return "R2";
      7: return "R7/R4";
      8: return "R7";
      9: return "R3";
      10: return "R3/R12";
      11, 13, 15: return "R12";
      12, 16: return "R10";
      14: return "R1";
      default: return "R13";
    endcase
  endfunction

  task automatic check(input string tag, input logic v_act, input logic [35:0] d_act,
                       input logic v_exp, input logic [35:0] d_exp);
    checks++;
    if (v_act !== v_exp || d_act !== d_exp) begin
      failures++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, v_act, d_act, v_exp, d_exp);
    end
  endtask

  task automatic idle();
    pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1; en1_n = 1'b1; en2 = 1'b0; en3_n = 1'b1;
    gwr_n = 1'b1; bwr_n = 1'b1; lane_sel_n = 4'hF; addr_i = '0; wdata_i = '0;
  endtask

  task automatic ctrl_load(input logic [AW-1:0] a);
    idle();
    cstb_n = 1'b0; en1_n = 1'b0; en2 = 1'b1; en3_n = 1'b0; addr_i = a;
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    oe_n = 1'b0; sleep_i = 1'b0; rst_n = 1'b0;
    repeat (3) tick();
    check("R13 reset", rvalid_o, rdata_o, 1'b0, 36'h0);
    rst_n = 1'b1;

    for (int i = 0; i < N; i++) begin
      logic [88:0] row;
      row = TBL[i];
      {pstb_n, cstb_n, adv_n, en1_n, en2, en3_n, gwr_n, bwr_n, lane_sel_n} = row[88:77];
      addr_i  = row[76:73];
      wdata_i = row[72:37];
      tick();
      check(row_tag(i), rvalid_o, rdata_o, row[36], row[35:0]);
    end

    // R1: load word 5 while active
    ctrl_load(4'd5);
    tick();
    check("R1 reload", rvalid_o, rdata_o, 1'b1, WC);

    // R9: output enable acts without a clock edge
    idle();
    #1 oe_n = 1'b1;
    #1 check("R9 oe high", rvalid_o, rdata_o, 1'b0, 36'h0);
    oe_n = 1'b0;
    #1 check("R9 oe low", rvalid_o, rdata_o, 1'b1, WC);

    // R11: sleep ignores a write-carrying load and hides the output
    @(negedge clk);
    ctrl_load(4'd4);
    gwr_n = 1'b0; wdata_i = WF; sleep_i = 1'b1;
    #1 check("R11 sleep output", rvalid_o, rdata_o, 1'b0, 36'h0);
    tick();
    check("R11 sleep edge", rvalid_o, rdata_o, 1'b0, 36'h0);
    idle();
    sleep_i = 1'b0;
    tick();
    check("R11 resume state", rvalid_o, rdata_o, 1'b1, WC);
    ctrl_load(4'd4);
    tick();
    check("R11 contents kept", rvalid_o, rdata_o, 1'b1, WB);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule